// File: doc/BRIEF.md
# DRAM Refresh Request Generator

This block keeps a set of DRAM banks refreshed. It takes a slow timebase pulse, one bus-clock-wide per crystal period. It divides that pulse by a fixed prescale and then by a programmable interval count. When an interval expires, it raises a refresh request to the bus arbiter. The request is held until the arbiter grants it. If intervals expire before a grant arrives, they are queued in a small saturating counter, so a late grant does not lose a refresh.

After a grant, the block runs one refresh cycle of a programmed length in bus clocks. The cycle is always CAS-before-RAS. The column strobe drops first, the row strobe joins it on the next clock, and both return high in the last clock. The same strobe pattern goes to every bank and every byte lane, because all banks share one DRAM mode and are refreshed together.

With a 3.6864 MHz timebase, an interval count of 13 gives a period of 56 timebase pulses. That is about 15.19 µs.

Top module: `dram_refresh_gen`

## Requirements
- R1: After reset, `ref_req` and `ref_busy` are 0 and every bit of `ras_n` and `cas_n` is 1.
- R2: While `refen` is 1, `ref_req` rises in the clock after the `(rfcnt+1)*4`-th sampled `xtal_tick` pulse, counted from enable or from the previous expiry. With `rfcnt`=13 this is 56 pulses.
- R3: While `refen` is 0, the prescaler and the interval counter stay at zero and queued requests are cleared. `ref_req` is 0 from the clock after `refen` is sampled low. After re-enabling, a full interval is needed again.
- R4: Once raised, `ref_req` stays 1 while no grant is given, however many clocks pass.
- R5: Up to 2 expired intervals are queued, and each is served by its own refresh cycle. An expiry that arrives while 2 are already queued is dropped.
- R6: When `ref_gnt` is sampled 1 while `ref_req` is 1, a refresh cycle starts in the next clock. Its length L comes from `rcyc`: 00 gives 8 clocks, 01 gives 6, 10 gives 5 and 11 gives 4.
- R7: In clock 1 of a refresh cycle, `cas_n` is 0 and `ras_n` is 1 (CAS before RAS).
- R8: In clocks 2 to L-1, `cas_n` and `ras_n` are both 0. In clock L, both are 1 and `ref_busy` is still 1. In the clock after clock L, `ref_busy` is 0.
- R9: `ref_req` is 0 while `ref_busy` is 1. A grant sampled while `ref_req` is 0 has no effect.
- R10: All bits of `ras_n` carry the same value, and all bits of `cas_n` carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_tick | input | 1 | One-clock pulse per timebase period |
| refen | input | 1 | Refresh enable |
| rfcnt | input | 8 | Interval count; period is (rfcnt+1)*4 ticks |
| rcyc | input | 2 | Refresh cycle length code |
| ref_gnt | input | 1 | Grant from the bus arbiter |
| ref_req | output | 1 | Refresh request to the bus arbiter |
| ref_busy | output | 1 | Refresh cycle in progress |
| ras_n | output | 4 | Row strobes, one per bank, active low |
| cas_n | output | 4 | Column strobes, one per byte lane, active low |

## Verification
The request is due in the first clock after the edge that samples the expiring tick. The bench therefore drives each tick for exactly one clock and checks at the falling edge right after that clock's rising edge. Strobe clock 1 is the clock after the edge that samples the grant, and each later strobe clock is checked one falling edge further on. The drop of `ref_busy` is checked one clock after clock L. Expected items are queued at the falling edge at which they are due, and the monitor compares them at that same falling edge, after the outputs have settled.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

   localparam int LEN_W = 4;

   // Refresh cycle length in bus clocks for each 2-bit code
   function automatic logic [LEN_W-1:0] cycle_len(input logic [1:0] code);
      logic [LEN_W-1:0] len;
      case (code)
         2'b00:   len = LEN_W'(8);
         2'b01:   len = LEN_W'(6);
         2'b10:   len = LEN_W'(5);
         default: len = LEN_W'(4);
      endcase
      return len;
   endfunction

endpackage

// File: rtl/rfsh_prescale.sv
module rfsh_prescale #(
   parameter int PRESCALE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic tick,
   output logic pre_fire
);
   localparam int PC_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
   localparam bit POW2 = (PRESCALE == (1 << PC_W));

   if (PRESCALE < 2) begin : g_bad_prescale
      $error("rfsh_prescale: PRESCALE must be at least 2");
   end

   logic [PC_W-1:0] pc_q;

   if (POW2) begin : g_wrap
      // Power-of-two divide: free wrap of the counter
      assign pre_fire = enable && tick && (&pc_q);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       pc_q <= '0;
         else if (!enable) pc_q <= '0;
         else if (tick)    pc_q <= pc_q + 1'b1;
      end
   end else begin : g_cmp
      // Arbitrary divide: compare and clear
      assign pre_fire = enable && tick && (pc_q == PC_W'(PRESCALE - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        pc_q <= '0;
         else if (!enable)  pc_q <= '0;
         else if (pre_fire) pc_q <= '0;
         else if (tick)     pc_q <= pc_q + 1'b1;
      end
   end

   p_pc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pc_q <= PC_W'(PRESCALE - 1));

   p_pc_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> pc_q == '0);

endmodule

// File: rtl/rfsh_period.sv
module rfsh_period #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             pre_fire,
   input  logic [CNT_W-1:0] limit,
   output logic             period_fire
);
   if (CNT_W < 1) begin : g_bad_width
      $error("rfsh_period: CNT_W must be positive");
   end

   logic [CNT_W-1:0] cnt_q;

   // Up-count avoids a load from the live field at reset
   assign period_fire = enable && pre_fire && (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (!enable)     cnt_q <= '0;
      else if (period_fire) cnt_q <= '0;
      else if (pre_fire)    cnt_q <= cnt_q + 1'b1;
   end

   p_cnt_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> cnt_q == '0);

   p_fire_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      period_fire |=> cnt_q == '0);

endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending #(
   parameter int MAX_PEND = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   input  logic dec,
   output logic any
);
   localparam int PEND_W = $clog2(MAX_PEND + 1);

   if (MAX_PEND < 1) begin : g_bad_depth
      $error("rfsh_pending: MAX_PEND must be at least 1");
   end

   logic [PEND_W-1:0] pend_q;

   assign any = (pend_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else if (clr) begin
         pend_q <= '0;
      end else if (inc && !dec) begin
         if (pend_q != PEND_W'(MAX_PEND)) pend_q <= pend_q + 1'b1;
      end else if (dec && !inc) begin
         pend_q <= pend_q - 1'b1;
      end
   end

   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q <= PEND_W'(MAX_PEND));

   p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> pend_q != '0);

   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !any);

endmodule

// File: rtl/rfsh_strobe_seq.sv
module rfsh_strobe_seq
   import rfsh_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [1:0] code,
   output logic       busy,
   output logic       cas_low,
   output logic       ras_low
);
   logic             act_q;
   logic [LEN_W-1:0] step_q;
   logic [LEN_W-1:0] len_q;
   logic             last;

   assign last    = act_q && (step_q == len_q);
   assign busy    = act_q;
   assign cas_low = act_q && !last;
   assign ras_low = act_q && !last && (step_q >= LEN_W'(2));

   // The length is latched at start so a code change mid-cycle has no effect
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         step_q <= '0;
         len_q  <= '0;
      end else if (!act_q) begin
         if (start) begin
            act_q  <= 1'b1;
            step_q <= LEN_W'(1);
            len_q  <= cycle_len(code);
         end
      end else if (last) begin
         act_q  <= 1'b0;
         step_q <= '0;
      end else begin
         step_q <= step_q + 1'b1;
      end
   end

   p_cas_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> cas_low && !ras_low);

   p_ras_after_cas_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_low) |-> $past(cas_low) && cas_low);

   p_release_together_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_low) && busy |-> !ras_low);

   p_release_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !cas_low |=> !busy);

endmodule

// File: rtl/dram_refresh_gen.sv
module dram_refresh_gen #(
   parameter int CNT_W     = 8,
   parameter int PRESCALE  = 4,
   parameter int MAX_PEND  = 2,
   parameter int NUM_BANKS = 4,
   parameter int NUM_LANES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 xtal_tick,
   input  logic                 refen,
   input  logic [CNT_W-1:0]     rfcnt,
   input  logic [1:0]           rcyc,
   input  logic                 ref_gnt,
   output logic                 ref_req,
   output logic                 ref_busy,
   output logic [NUM_BANKS-1:0] ras_n,
   output logic [NUM_LANES-1:0] cas_n
);
   if (NUM_BANKS < 1 || NUM_LANES < 1) begin : g_bad_fanout
      $error("dram_refresh_gen: NUM_BANKS and NUM_LANES must be positive");
   end

   logic pre_fire;
   logic period_fire;
   logic pend_any;
   logic start;
   logic busy;
   logic cas_low;
   logic ras_low;

   rfsh_prescale #(.PRESCALE(PRESCALE)) u_prescale (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (refen),
      .tick     (xtal_tick),
      .pre_fire (pre_fire)
   );

   rfsh_period #(.CNT_W(CNT_W)) u_period (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (refen),
      .pre_fire    (pre_fire),
      .limit       (rfcnt),
      .period_fire (period_fire)
   );

   assign ref_req = pend_any && !busy;
   assign start   = ref_req && ref_gnt;

   rfsh_pending #(.MAX_PEND(MAX_PEND)) u_pending (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!refen),
      .inc   (period_fire),
      .dec   (start),
      .any   (pend_any)
   );

   rfsh_strobe_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .code    (rcyc),
      .busy    (busy),
      .cas_low (cas_low),
      .ras_low (ras_low)
   );

   assign ref_busy = busy;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign ras_n[b] = !ras_low;
   end

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      assign cas_n[l] = !cas_low;
   end

   p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req && !ref_gnt && refen |=> ref_req);

   p_off_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !refen |=> !ref_req);

   p_no_req_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ref_busy |-> !ref_req);

   p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req && ref_gnt |=> ref_busy && cas_n[0] == 1'b0 && ras_n[0] == 1'b1);

   p_lanes_equal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_n == '0 || ras_n == '1) && (cas_n == '0 || cas_n == '1));

   p_idle_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_busy |-> ras_n == '1 && cas_n == '1);

endmodule

// File: tb/dram_refresh_gen_bench.sv
module dram_refresh_gen_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 4;
   localparam int NL = 4;

   typedef struct {
      logic  req;
      logic  busy;
      logic  ras;
      logic  cas;
      string tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          xtal_tick = 1'b0;
   logic          refen = 1'b0;
   logic [7:0]    rfcnt = 8'd2;
   logic [1:0]    rcyc = 2'b00;
   logic          ref_gnt = 1'b0;
   logic          ref_req;
   logic          ref_busy;
   logic [NB-1:0] ras_n;
   logic [NL-1:0] cas_n;

   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_refresh_gen u_dram_refresh_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .xtal_tick (xtal_tick),
      .refen     (refen),
      .rfcnt     (rfcnt),
      .rcyc      (rcyc),
      .ref_gnt   (ref_gnt),
      .ref_req   (ref_req),
      .ref_busy  (ref_busy),
      .ras_n     (ras_n),
      .cas_n     (cas_n)
   );

   // Monitor: compare queued expectations once outputs settle
   always @(negedge clk) begin
      #1;
      while (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_checks++;
         if (ref_req !== e.req || ref_busy !== e.busy ||
             ras_n !== {NB{e.ras}} || cas_n !== {NL{e.cas}}) begin
            n_fail++;
            $display("FAIL %s: got req=%b busy=%b ras_n=%b cas_n=%b, expected req=%b busy=%b ras_n=%b cas_n=%b",
                     e.tag, ref_req, ref_busy, ras_n, cas_n,
                     e.req, e.busy, {NB{e.ras}}, {NL{e.cas}});
         end
      end
   end

   task automatic expect_now(input logic req, input logic busy,
                             input logic ras, input logic cas, input string tag);
      exp_t e;
      e.req = req; e.busy = busy; e.ras = ras; e.cas = cas; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic send_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); xtal_tick = 1'b1;
         @(negedge clk); xtal_tick = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Grant a pending request and follow the strobes clock by clock
   task automatic run_refresh(input int len, input logic req_after, input string tag);
      @(negedge clk); ref_gnt = 1'b1;
      @(negedge clk); ref_gnt = 1'b0;
      expect_now(1'b0, 1'b1, 1'b1, 1'b0, {tag, " R7 clock 1 CAS first"});
      for (int c = 2; c < len; c++) begin
         @(negedge clk);
         expect_now(1'b0, 1'b1, 1'b0, 1'b0, {tag, " R8 middle clock"});
      end
      @(negedge clk);
      expect_now(1'b0, 1'b1, 1'b1, 1'b1, {tag, " R8 last clock"});
      @(negedge clk);
      expect_now(req_after, 1'b0, 1'b1, 1'b1, {tag, " R8 busy released"});
   endtask

   initial begin
      idle(3);
      expect_now(1'b0, 1'b0, 1'b1, 1'b1, "R1 reset state");
      @(negedge clk); rst_n = 1'b1;
      idle(2);
      expect_now(1'b0, 1'b0, 1'b1, 1'b1, "R1 after reset release");

      // Period with rfcnt=2: 12 ticks
      refen = 1'b1; rfcnt = 8'd2; rcyc = 2'b00;
      send_ticks(11);
      expect_now(1'b0, 1'b0, 1'b1, 1'b1, "R2 no request before 12th tick");
      send_ticks(1);
      expect_now(1'b1, 1'b0, 1'b1, 1'b1, "R2 request after 12th tick");
      idle(20);
      expect_now(1'b1, 1'b0, 1'b1, 1'b1, "R4 request held without grant");
      run_refresh(8, 1'b0, "R6 code 00 len 8");

      // Stray grant with no request
      @(negedge clk); ref_gnt = 1'b1;
      @(negedge clk); ref_gnt = 1'b0;
      expect_now(1'b0, 1'b0, 1'b1, 1'b1, "R9 grant without request ignored");
      idle(3);
      expect_now(1'b0, 1'b0, 1'b1, 1'b1, "R9 still idle after stray grant");

      rcyc = 2'b01;
      send_ticks(12);
      expect_now(1'b1, 1'b0, 1'b1, 1'b1, "R2 second period");
      run_refresh(6, 1'b0, "R6 code 01 len 6");

      rcyc = 2'b10;
      send_ticks(12);
      run_refresh(5, 1'b0, "R6 code 10 len 5");

      rcyc = 2'b11;
      send_ticks(12);
      run_refresh(4, 1'b0, "R6 code 11 len 4");

      // Queue depth with rfcnt=0: three expiries, two served
      rfcnt = 8'd0;
      send_ticks(4);
      expect_now(1'b1, 1'b0, 1'b1, 1'b1, "R2 rfcnt 0 period of 4 ticks");
      send_ticks(8);
      expect_now(1'b1, 1'b0, 1'b1, 1'b1, "R5 request still up with queue full");
      run_refresh(4, 1'b1, "R5 first queued refresh");
      run_refresh(4, 1'b0, "R5 second queued refresh, third dropped");

      // Disable mid period, then re-enable
      rfcnt = 8'd2;
      send_ticks(6);
      @(negedge clk); refen = 1'b0;
      send_ticks(20);
      expect_now(1'b0, 1'b0, 1'b1, 1'b1, "R3 no request while disabled");
      @(negedge clk); refen = 1'b1;
      send_ticks(11);
      expect_now(1'b0, 1'b0, 1'b1, 1'b1, "R3 full interval needed after enable");
      send_ticks(1);
      expect_now(1'b1, 1'b0, 1'b1, 1'b1, "R3 request after full interval");
      @(negedge clk); refen = 1'b0;
      @(negedge clk);
      expect_now(1'b0, 1'b0, 1'b1, 1'b1, "R3 disable clears pending request");

      // 15.19 us interval: rfcnt=13 gives 56 ticks
      @(negedge clk); refen = 1'b1; rfcnt = 8'd13;
      send_ticks(55);
      expect_now(1'b0, 1'b0, 1'b1, 1'b1, "R2 rfcnt 13 before 56th tick");
      send_ticks(1);
      expect_now(1'b1, 1'b0, 1'b1, 1'b1, "R2 rfcnt 13 at 56th tick");
      run_refresh(4, 1'b0, "R10 all banks and lanes together");

      idle(3);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got no finish, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule